// File: doc/BRIEF.md
# Received Flow-Control Frame Detector

This block sits on the receive byte stream of an Ethernet MAC, after preamble removal. It forwards every byte to the user side one cycle later, without changes. In parallel, it parses the header of each frame to find MAC control frames aimed at this station. Such a frame is either a classic Pause frame, which pauses the whole link, or a priority flow-control frame, which carries one pause time per traffic class.

A control frame is accepted when its destination address matches one of two addresses: the programmed station address or the reserved flow-control multicast address. After the last byte of an accepted frame, and only when the frame check was good, the block pulses per-queue duration outputs. Each pulse carries a 16-bit quanta value and a resume (XON) flag for a zero quanta. For a classic Pause frame, the block can also pulse a transmit-stop request when that feature is switched on. Frame check sequence validation is done upstream and arrives as a flag with the last byte.

A small configuration port loads the station address, the per-queue receive enables and the transmit-stop enable together.

Top module: `fcd_rx_detect`

## Requirements
- R1: Every input beat (valid, data, start, end) appears unchanged on the output port exactly one clock later, whatever the frame content or configuration.
- R2: A frame is acted on only if bytes 0..5 (first byte = most significant address byte) equal either the programmed station address or 01-80-C2-00-00-01; a difference in any one byte means no action.
- R3: Bytes 12..13 must be 0x88,0x08; bytes 14..15 equal to 0x0001 mark a classic Pause frame, 0x0101 a priority frame; any other type or opcode gives no action.
- R4: In a priority frame, byte 17 bit i enables class i, and the quanta of class i is byte 18+2i (high) and byte 19+2i (low). Queue i reports only if its class bit and its receive-enable bit are both 1.
- R5: A reported quanta of zero raises the queue's XON flag in the same pulse; a nonzero quanta leaves it low.
- R6: A classic Pause frame reports its quanta (bytes 16..17, high first) on queue 0 if queue 0 is enabled, and pulses the transmit-stop output with that quanta only if the transmit-stop enable is 1.
- R7: All action outputs pulse for one cycle, in the second cycle after the end byte, and only if the good-check flag is high with that byte and the frame reached byte 17 (Pause) or byte 19+2*(NQ-1) (priority); otherwise they stay low.
- R8: Reset clears all outputs and sets the station address to 01-80-C2-00-00-01, all queue enables to 1 and the transmit-stop enable to 0; a configuration write loads all three at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | First byte of a frame |
| in_eop | input | 1 | Last byte of a frame |
| in_fcs_ok | input | 1 | Frame check good, sampled with the last byte |
| cfg_wr | input | 1 | Load configuration |
| cfg_station_addr | input | 48 | Station address, first byte in bits 47:40 |
| cfg_queue_en | input | NQ | Per-queue receive enable |
| cfg_tx_pause_en | input | 1 | Enable the transmit-stop request |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sop | output | 1 | Forwarded first-byte flag |
| out_eop | output | 1 | Forwarded last-byte flag |
| dur_valid | output | NQ | Per-queue duration pulse |
| dur_quanta | output | 16*NQ | Per-queue quanta, queue i in bits 16i+15:16i |
| dur_xon | output | NQ | Per-queue resume flag (quanta zero) |
| tx_stop_valid | output | 1 | Transmit-stop request pulse |
| tx_stop_quanta | output | 16 | Pause time for the transmit-stop request |

## Verification
The assertions assume that frames follow each other with at least two cycles between end bytes, which any frame long enough to be a control frame satisfies. They also assume that in_sop marks the first byte of every frame. The stimulus always sends complete frames with one start and one end flag, and it leaves idle cycles after each frame before the next one. Configuration writes happen only between frames, so the enables the assertions see one cycle before a pulse are the ones the decision used.

// File: rtl/fcd_pkg.sv
// Package: shared constants for the received flow-control frame detector.
// Byte offsets count from the first destination-address byte (index 0).
package fcd_pkg;
    localparam logic [47:0] FC_MCAST_ADDR = 48'h0180C2000001;
    localparam logic [15:0] FC_ETYPE      = 16'h8808;
    localparam logic [15:0] FC_OP_PAUSE   = 16'h0001;
    localparam logic [15:0] FC_OP_PRIO    = 16'h0101;
    localparam int          OFS_TYPE      = 12;
    localparam int          OFS_OPCODE    = 14;
    localparam int          OFS_WORD      = 16;
    localparam int          OFS_QUANTA    = 18;
    localparam int          QUANTA_W      = 16;
endpackage

// File: rtl/fcd_cfg_regs.sv
// Module: configuration registers of the detector.
// Holds station address, per-queue receive enables and transmit-stop enable.
// Assumes writes occur only between frames; all fields load on one strobe.
module fcd_cfg_regs #(
    parameter int NQ = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [47:0]   wr_station,
    input  logic [NQ-1:0] wr_queue_en,
    input  logic          wr_pause_en,
    output logic [47:0]   station,
    output logic [NQ-1:0] queue_en,
    output logic          pause_en
);
    import fcd_pkg::*;

    // Load all configuration fields on a write, reset to defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            station  <= FC_MCAST_ADDR;
            queue_en <= '1;
            pause_en <= 1'b0;
        end else if (wr) begin
            station  <= wr_station;
            queue_en <= wr_queue_en;
            pause_en <= wr_pause_en;
        end
    end

    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(queue_en) && $stable(pause_en) && $stable(station));
endmodule

// File: rtl/fcd_header_match.sv
// Module: byte counter and header field matcher.
// Tracks the byte index within a frame and records whether the destination
// matches the station or multicast address, whether the type is MAC control,
// the opcode and the 16-bit word following it. Assumes in_sop marks byte 0.
module fcd_header_match #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_vld,
    input  logic [7:0]       byte_data,
    input  logic             byte_sop,
    input  logic [47:0]      station,
    output logic [IDX_W-1:0] cur_idx,
    output logic             own_ok,
    output logic             mc_ok,
    output logic             type_ok,
    output logic [15:0]      opcode,
    output logic [15:0]      word16
);
    import fcd_pkg::*;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       own_hit;
    logic [7:0]       mc_hit;
    logic             in_da;
    logic             first;

    // Byte index of the current beat: zero on a frame start.
    assign cur_idx = byte_sop ? '0 : idx_q;
    assign in_da   = cur_idx < IDX_W'(6);
    assign first   = cur_idx == '0;

    // Per-position address byte comparators; positions 6 and 7 never hit.
    for (genvar k = 0; k < 8; k++) begin : g_hit
        if (k < 6) begin : g_cmp
            assign own_hit[k] = byte_data == station[47-8*k -: 8];
            assign mc_hit[k]  = byte_data == FC_MCAST_ADDR[47-8*k -: 8];
        end else begin : g_pad
            assign own_hit[k] = 1'b0;
            assign mc_hit[k]  = 1'b0;
        end
    end

    // Saturating byte counter and header field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            own_ok  <= 1'b0;
            mc_ok   <= 1'b0;
            type_ok <= 1'b0;
            opcode  <= '0;
            word16  <= '0;
        end else if (byte_vld) begin
            idx_q <= (&cur_idx) ? cur_idx : cur_idx + 1'b1;
            if (in_da) begin
                own_ok <= (first | own_ok) & own_hit[cur_idx[2:0]];
                mc_ok  <= (first | mc_ok) & mc_hit[cur_idx[2:0]];
            end
            if (first) begin
                type_ok <= 1'b0;
                opcode  <= '0;
                word16  <= '0;
            end
            if (cur_idx == IDX_W'(OFS_TYPE))
                type_ok <= byte_data == FC_ETYPE[15:8];
            if (cur_idx == IDX_W'(OFS_TYPE + 1))
                type_ok <= type_ok & (byte_data == FC_ETYPE[7:0]);
            if (cur_idx == IDX_W'(OFS_OPCODE))
                opcode[15:8] <= byte_data;
            if (cur_idx == IDX_W'(OFS_OPCODE + 1))
                opcode[7:0] <= byte_data;
            if (cur_idx == IDX_W'(OFS_WORD))
                word16[15:8] <= byte_data;
            if (cur_idx == IDX_W'(OFS_WORD + 1))
                word16[7:0] <= byte_data;
        end
    end

    p_type_needs_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(type_ok) |-> $past(byte_vld) && ($past(cur_idx) == IDX_W'(OFS_TYPE)));
endmodule

// File: rtl/fcd_quanta_capture.sv
// Module: per-queue quanta capture for priority flow-control frames.
// Queue i takes bytes OFS_QUANTA+2i (high) and OFS_QUANTA+2i+1 (low).
// Assumes the byte index comes from the header matcher of the same stream.
module fcd_quanta_capture #(
    parameter int NQ    = 8,
    parameter int IDX_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         byte_vld,
    input  logic [7:0]                   byte_data,
    input  logic [IDX_W-1:0]             cur_idx,
    output logic [NQ*fcd_pkg::QUANTA_W-1:0] quanta
);
    import fcd_pkg::*;

    for (genvar i = 0; i < NQ; i++) begin : g_q
        localparam int HI = OFS_QUANTA + 2 * i;
        // Capture the two quanta bytes of queue i.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                quanta[i*QUANTA_W +: QUANTA_W] <= '0;
            end else if (byte_vld) begin
                if (cur_idx == IDX_W'(HI))
                    quanta[i*QUANTA_W+8 +: 8] <= byte_data;
                if (cur_idx == IDX_W'(HI + 1))
                    quanta[i*QUANTA_W +: 8] <= byte_data;
            end
        end
    end
endmodule

// File: rtl/fcd_rx_detect.sv
// Module: received Pause / priority flow-control frame detector (top).
// Forwards the byte stream with one cycle of delay and, after the end byte of
// a good control frame addressed to this station, pulses per-queue durations
// and optionally a transmit-stop request. Assumes FCS is checked upstream and
// that end bytes of consecutive frames are at least two cycles apart.
module fcd_rx_detect #(
    parameter int NQ    = 8,
    parameter int IDX_W = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    input  logic                 in_sop,
    input  logic                 in_eop,
    input  logic                 in_fcs_ok,
    input  logic                 cfg_wr,
    input  logic [47:0]          cfg_station_addr,
    input  logic [NQ-1:0]        cfg_queue_en,
    input  logic                 cfg_tx_pause_en,
    output logic                 out_valid,
    output logic [7:0]           out_data,
    output logic                 out_sop,
    output logic                 out_eop,
    output logic [NQ-1:0]        dur_valid,
    output logic [NQ*16-1:0]     dur_quanta,
    output logic [NQ-1:0]        dur_xon,
    output logic                 tx_stop_valid,
    output logic [15:0]          tx_stop_quanta
);
    import fcd_pkg::*;

    localparam int PAUSE_LAST = OFS_WORD + 1;
    localparam int PRIO_LAST  = OFS_QUANTA + 2 * NQ - 1;

    logic [47:0]          station;
    logic [NQ-1:0]        queue_en;
    logic                 pause_en;
    logic [IDX_W-1:0]     cur_idx;
    logic                 own_ok, mc_ok, type_ok;
    logic [15:0]          opcode, word16;
    logic [NQ*16-1:0]     cap_quanta;
    logic                 pend, pend_fcs;
    logic [IDX_W-1:0]     pend_last;
    logic                 frame_ok, is_pause, is_prio;
    logic [NQ-1:0]        dv_n, xon_n;
    logic [NQ*16-1:0]     dq_n;

    fcd_cfg_regs #(.NQ(NQ)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
        .wr_station(cfg_station_addr), .wr_queue_en(cfg_queue_en),
        .wr_pause_en(cfg_tx_pause_en),
        .station(station), .queue_en(queue_en), .pause_en(pause_en)
    );

    fcd_header_match #(.IDX_W(IDX_W)) u_hdr (
        .clk(clk), .rst_n(rst_n), .byte_vld(in_valid), .byte_data(in_data),
        .byte_sop(in_sop), .station(station), .cur_idx(cur_idx),
        .own_ok(own_ok), .mc_ok(mc_ok), .type_ok(type_ok),
        .opcode(opcode), .word16(word16)
    );

    fcd_quanta_capture #(.NQ(NQ), .IDX_W(IDX_W)) u_qcap (
        .clk(clk), .rst_n(rst_n), .byte_vld(in_valid), .byte_data(in_data),
        .cur_idx(cur_idx), .quanta(cap_quanta)
    );

    // Forward every beat one cycle later, unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sop   <= 1'b0;
            out_eop   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_data  <= in_data;
            out_sop   <= in_sop & in_valid;
            out_eop   <= in_eop & in_valid;
        end
    end

    // Remember an ended frame, its check flag and its last byte index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_fcs  <= 1'b0;
            pend_last <= '0;
        end else begin
            pend      <= in_valid & in_eop;
            pend_fcs  <= in_fcs_ok;
            pend_last <= cur_idx;
        end
    end

    // Classify the ended frame from the captured header fields.
    always_comb begin
        frame_ok = pend & pend_fcs & (own_ok | mc_ok) & type_ok;
        is_pause = frame_ok & (opcode == FC_OP_PAUSE) & (pend_last >= IDX_W'(PAUSE_LAST));
        is_prio  = frame_ok & (opcode == FC_OP_PRIO) & (pend_last >= IDX_W'(PRIO_LAST));
    end

    // Per-queue decision: class bit and enable for priority, queue 0 for Pause.
    for (genvar i = 0; i < NQ; i++) begin : g_dec
        if (i == 0) begin : g_q0
            assign dv_n[i] = queue_en[i] & ((is_prio & word16[i]) | is_pause);
            assign dq_n[i*16 +: 16] = is_pause ? word16 : cap_quanta[i*16 +: 16];
        end else begin : g_qn
            assign dv_n[i] = queue_en[i] & is_prio & word16[i];
            assign dq_n[i*16 +: 16] = cap_quanta[i*16 +: 16];
        end
        assign xon_n[i] = dq_n[i*16 +: 16] == 16'h0000;
    end

    // Register the action outputs as single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dur_valid      <= '0;
            dur_quanta     <= '0;
            dur_xon        <= '0;
            tx_stop_valid  <= 1'b0;
            tx_stop_quanta <= '0;
        end else begin
            dur_valid      <= dv_n;
            dur_quanta     <= dq_n;
            dur_xon        <= xon_n & dv_n;
            tx_stop_valid  <= is_pause & pause_en;
            tx_stop_quanta <= word16;
        end
    end

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dur_valid & ~$past(queue_en)) == '0);
    p_stop_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop_valid |-> $past(pause_en));
    p_stop_q0_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stop_valid |-> (dur_valid >> 1) == '0);
    p_after_eop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dur_valid || tx_stop_valid) |-> $past(in_valid && in_eop && in_fcs_ok, 2));
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|dur_valid) |=> !(|dur_valid));
endmodule

// File: tb/tb_fcd_rx_detect.sv
module tb_fcd_rx_detect;
    localparam int CLK_NS = 10;
    localparam int NQ     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_fcs_ok = 1'b0;
    logic [7:0]        in_data = '0;
    logic              cfg_wr = 1'b0, cfg_tx_pause_en = 1'b0;
    logic [47:0]       cfg_station_addr = '0;
    logic [NQ-1:0]     cfg_queue_en = '0;
    logic              out_valid, out_sop, out_eop, tx_stop_valid;
    logic [7:0]        out_data;
    logic [NQ-1:0]     dur_valid, dur_xon;
    logic [NQ*16-1:0]  dur_quanta;
    logic [15:0]       tx_stop_quanta;

    fcd_rx_detect #(.NQ(NQ)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sop(in_sop), .in_eop(in_eop), .in_fcs_ok(in_fcs_ok),
        .cfg_wr(cfg_wr), .cfg_station_addr(cfg_station_addr),
        .cfg_queue_en(cfg_queue_en), .cfg_tx_pause_en(cfg_tx_pause_en),
        .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
        .dur_valid(dur_valid), .dur_quanta(dur_quanta), .dur_xon(dur_xon),
        .tx_stop_valid(tx_stop_valid), .tx_stop_quanta(tx_stop_quanta)
    );

    always #(CLK_NS/2) clk = ~clk;

    int errors = 0, checks = 0;
    logic mon_on = 1'b0;
    int pt_err = 0, pt_n = 0;
    int seen_cnt [NQ];
    logic [15:0] seen_q [NQ];
    logic seen_x [NQ];
    int stop_cnt = 0;
    logic [15:0] stop_q = '0;
    logic [NQ-1:0] tb_qen = '1;
    logic tb_pen = 1'b0;
    logic [47:0] tb_own = 48'h0180C2000001;
    logic p_valid = 1'b0, p_sop = 1'b0, p_eop = 1'b0;
    logic [7:0] p_data = '0;

    // Capture inputs at the edge for the pass-through comparison.
    always @(posedge clk) begin
        p_valid <= in_valid;
        p_data  <= in_data;
        p_sop   <= in_sop & in_valid;
        p_eop   <= in_eop & in_valid;
    end

    // Monitor outputs between edges.
    always @(negedge clk) begin
        if (mon_on) begin
            pt_n++;
            if (out_valid !== p_valid ||
                (p_valid && {out_data, out_sop, out_eop} !== {p_data, p_sop, p_eop}))
                pt_err++;
            for (int q = 0; q < NQ; q++) begin
                if (dur_valid[q]) begin
                    seen_cnt[q]++;
                    seen_q[q] = dur_quanta[q*16 +: 16];
                    seen_x[q] = dur_xon[q];
                end
            end
            if (tx_stop_valid) begin
                stop_cnt++;
                stop_q = tx_stop_quanta;
            end
        end
    end

    task automatic summary_and_end();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL R7 watchdog: actual=running expected=finished");
        summary_and_end();
    end

    task automatic program_cfg(input logic [47:0] own, input logic [NQ-1:0] qen, input logic pen);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_station_addr = own; cfg_queue_en = qen; cfg_tx_pause_en = pen;
        @(negedge clk);
        cfg_wr = 1'b0;
        tb_own = own; tb_qen = qen; tb_pen = pen;
    endtask

    // sel: 0 multicast, 1 station, 2 multicast with last byte changed,
    //      3 station with first byte changed, 4 multicast with byte 3 changed
    task automatic send_frame(input int sel, input logic [15:0] etype, input logic [15:0] op,
                              input logic [15:0] w16, input logic [15:0] qbase,
                              input logic [7:0] zmask, input int len, input logic fcs,
                              input string req);
        logic [7:0]  fr [64];
        logic [47:0] da;
        logic [15:0] qv [NQ];
        logic        addr_ok, type_ok, is_pause, is_prio, ev, ex, es;
        logic [15:0] eq;
        case (sel)
            0: da = 48'h0180C2000001;
            1: da = tb_own;
            2: da = 48'h0180C2000002;
            3: da = tb_own ^ 48'h010000000000;
            default: da = 48'h0180C2100001;
        endcase
        for (int i = 0; i < NQ; i++)
            qv[i] = zmask[i] ? 16'h0000 : qbase + 16'(i) * 16'h0101;
        for (int b = 0; b < 64; b++) fr[b] = 8'hA0 ^ 8'(b);
        for (int b = 0; b < 6; b++) fr[b] = da[47-8*b -: 8];
        for (int b = 6; b < 12; b++) fr[b] = 8'h10 + 8'(b);
        fr[12] = etype[15:8]; fr[13] = etype[7:0];
        fr[14] = op[15:8];    fr[15] = op[7:0];
        fr[16] = w16[15:8];   fr[17] = w16[7:0];
        for (int i = 0; i < NQ; i++) begin
            fr[18+2*i] = qv[i][15:8];
            fr[19+2*i] = qv[i][7:0];
        end
        for (int q = 0; q < NQ; q++) seen_cnt[q] = 0;
        stop_cnt = 0;
        for (int b = 0; b < len; b++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fr[b];
            in_sop = (b == 0); in_eop = (b == len - 1); in_fcs_ok = fcs;
        end
        @(negedge clk);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_fcs_ok = 1'b0;
        repeat (4) @(negedge clk);
        addr_ok  = (da == 48'h0180C2000001) || (da == tb_own);
        type_ok  = etype == 16'h8808;
        is_pause = fcs && addr_ok && type_ok && op == 16'h0001 && (len - 1) >= 17;
        is_prio  = fcs && addr_ok && type_ok && op == 16'h0101 && (len - 1) >= 19 + 2*(NQ-1);
        for (int q = 0; q < NQ; q++) begin
            ev = tb_qen[q] && ((is_prio && w16[q]) || (q == 0 && is_pause));
            eq = is_pause ? w16 : qv[q];
            ex = eq == 16'h0000;
            checks++;
            if (seen_cnt[q] != int'(ev) ||
                (ev && (seen_q[q] !== eq || seen_x[q] !== ex))) begin
                errors++;
                $display("FAIL %s queue %0d: actual cnt=%0d q=%h xon=%b expected cnt=%0d q=%h xon=%b",
                         req, q, seen_cnt[q], seen_q[q], seen_x[q], ev, eq, ex);
            end
        end
        es = is_pause && tb_pen;
        checks++;
        if (stop_cnt != int'(es) || (es && stop_q !== w16)) begin
            errors++;
            $display("FAIL %s stop: actual cnt=%0d q=%h expected cnt=%0d q=%h",
                     req, stop_cnt, stop_q, es, w16);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state of the outputs
        checks++;
        if (out_valid !== 1'b0 || dur_valid !== '0 || tx_stop_valid !== 1'b0) begin
            errors++;
            $display("FAIL R8 reset outputs: actual v=%b d=%b s=%b expected 0 0 0",
                     out_valid, dur_valid, tx_stop_valid);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R8: default enables (all queues on, transmit stop off)
        send_frame(0, 16'h8808, 16'h0001, 16'h1234, 16'h0, 8'h00, 60, 1'b1, "R8");
        send_frame(1, 16'h8808, 16'h0101, 16'h00FF, 16'h0200, 8'h00, 60, 1'b1, "R8");

        // R2 R3 R7: address, type, opcode and check-flag sweep
        program_cfg(48'h02AABBCCDDEE, '1, 1'b1);
        for (int sel = 0; sel < 5; sel++)
            for (int oi = 0; oi < 4; oi++)
                for (int f = 0; f < 2; f++) begin
                    logic [15:0] op;
                    op = (oi == 0) ? 16'h0001 : (oi == 1) ? 16'h0101 : (oi == 2) ? 16'h0102 : 16'h0100;
                    send_frame(sel, 16'h8808, op, (oi == 1) ? 16'h00C3 : 16'h0345,
                               16'h3000, 8'h00, 64, f[0], "R2_R3");
                end
        send_frame(0, 16'h8809, 16'h0101, 16'h00FF, 16'h0100, 8'h00, 64, 1'b1, "R3");
        send_frame(0, 16'h0808, 16'h0001, 16'h0100, 16'h0100, 8'h00, 64, 1'b1, "R3");

        // R4 R5: every class vector with a fixed enable pattern
        program_cfg(48'h02AABBCCDDEE, 8'h5A, 1'b1);
        for (int c = 0; c < 256; c++)
            send_frame(1, 16'h8808, 16'h0101, 16'(c), 16'h1000 + 16'(c), 8'h81, 40, 1'b1, "R4_R5");

        // R4: every enable pattern with all classes requested
        for (int e = 0; e < 256; e++) begin
            program_cfg(48'h02AABBCCDDEE, 8'(e), 1'b1);
            send_frame(0, 16'h8808, 16'h0101, 16'h00FF, 16'h0400, 8'h24, 36, 1'b1, "R4");
        end

        // R6 R5: Pause frames with each stop-enable and queue-0 enable
        for (int m = 0; m < 4; m++) begin
            program_cfg(48'h02AABBCCDDEE, {7'h7F, m[0]}, m[1]);
            send_frame(0, 16'h8808, 16'h0001, 16'hBEEF, 16'h0, 8'h00, 60, 1'b1, "R6");
            send_frame(1, 16'h8808, 16'h0001, 16'h0000, 16'h0, 8'h00, 60, 1'b1, "R6_R5");
        end

        // R7: frame-length boundaries for both frame kinds
        program_cfg(48'h02AABBCCDDEE, '1, 1'b1);
        for (int len = 10; len <= 40; len++) begin
            send_frame(0, 16'h8808, 16'h0001, 16'h0077, 16'h0, 8'h00, len, 1'b1, "R7");
            send_frame(0, 16'h8808, 16'h0101, 16'h00A5, 16'h0500, 8'h10, len, 1'b1, "R7");
        end

        // R1: pass-through over the whole run
        checks++;
        if (pt_err != 0 || pt_n == 0) begin
            errors++;
            $display("FAIL R1 pass-through: actual mismatches=%0d of %0d expected 0", pt_err, pt_n);
        end
        summary_and_end();
    end
endmodule